// File: doc/BRIEF.md
# Cascaded Biquad Sequencer

This block filters a stream of integer samples through four second-order sections in series: one highpass section, then three notch sections. Each section is a direct form II biquad with its own pair of delay states. All the arithmetic runs on one pipelined multiplier and one pipelined saturating adder. A sequencing state machine issues one operation at a time, and it waits for each result before it issues any operation that depends on that result. The block is used where samples arrive slowly compared with the clock, for example a few kilosamples per second. In that case one long-latency arithmetic pair can serve the whole chain instead of parallel multipliers for every tap.

A sample is presented with a one-cycle strobe. It is converted to signed Q2.30 and then passed through the sections in order, and the output of each section becomes the input of the next. When the last section finishes, the result appears with a one-cycle valid pulse. A rate select input, captured when the sample is accepted, picks which coefficient set is used for that sample. A strobe that arrives while a sample is being processed is dropped, and a sticky flag records the loss.

Top module: `biq_cascade_engine`

## Requirements
- R1: An accepted sample `in_data` (signed, IN_W bits) is converted to Q2.30 by sign extension to 32 bits followed by a left shift of 31-IN_W. The input is therefore read as a fraction with IN_W-1 fractional bits.
- R2: Each section computes its result in this fixed order: m=a1·w1, t=x−m, m=a2·w2, w=t−m, acc=b0·w, m=b1·w1, acc=acc+m, m=b2·w2, y=acc+m. A multiply takes the full 64-bit product, shifts it arithmetically right by 30 (rounding toward minus infinity) and saturates the result to 32 bits. An add or subtract saturates to the signed 32-bit range.
- R3: One multiplier and one adder serve the whole chain. At most one of them is issued an operation in any cycle.
- R4: No operation is issued while an earlier result is still in flight. A sample therefore needs at least 36·25 = 900 cycles from acceptance to output at the default latencies of 25.
- R5: Four sections run per sample: the highpass (section 0) first, then notch sections 1, 2 and 3. `out_data` carries y of section 3, and `out_valid` is high for exactly one cycle per accepted sample, at a time when `busy` is low.
- R6: After a section finishes, its delay states update as w2←w1 and w1←w. These states carry over from one sample to the next.
- R7: `rate_sel` is captured when the sample is accepted and selects the coefficient set for every section of that sample. The coefficient of (set, section, index) is the value of `biq_pkg::biq_coef`, with index 0..4 meaning b0, b1, b2, a1, a2.
- R8: At the default latencies, the output appears no more than 1000 cycles after the strobe is accepted, which is far inside one 62.5 µs sample period at 200 MHz.
- R9: A strobe that arrives while `busy` is high is dropped. It produces no output and does not change the delay states. `overrun` rises in the cycle after the strobe and stays high until reset.
- R10: A synchronous reset clears every delay state, returns the sequencer to idle, and drives `busy`, `out_valid` and `overrun` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe |
| in_data | input | IN_W | Signed integer sample |
| rate_sel | input | SEL_W | Coefficient set select, captured on acceptance |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | 32 | Filtered sample, signed Q2.30 |
| busy | output | 1 | High while a sample is in the chain |
| overrun | output | 1 | Sticky flag: a sample was dropped |

## Verification
The hardest case to reach from the ports is a strobe that lands while the chain is busy. If the block handled it wrongly, that strobe could still disturb the stored delay states, and the damage would only show on a later sample. The stimulus therefore primes the states, sends a sample, and injects a second strobe partway through. It then confirms that no extra output appears and that the following sample matches a reference that never saw the dropped value. Impulse and step responses for both coefficient sets are compared bit for bit against a Q2.30 model in the bench that follows the same operation order.

// File: rtl/biq_pkg.sv
package biq_pkg;
  localparam int QW    = 32;
  localparam int QF    = 30;
  localparam int NSEC  = 4;
  localparam int NSETS = 2;
  localparam int NCOEF = 5;

  typedef logic signed [QW-1:0] q_t;

  // coefficient index encoding
  localparam logic [2:0] CI_B0 = 3'd0;
  localparam logic [2:0] CI_B1 = 3'd1;
  localparam logic [2:0] CI_B2 = 3'd2;
  localparam logic [2:0] CI_A1 = 3'd3;
  localparam logic [2:0] CI_A2 = 3'd4;

  // clamp a wide value to the signed Q range
  function automatic q_t q_clamp(input logic signed [63:0] v);
    if (v > 64'sd2147483647)       return 32'sh7fffffff;
    else if (v < -64'sd2147483648) return 32'sh80000000;
    else                           return q_t'(v);
  endfunction

  // Q2.30 product, floor rounding, saturated
  function automatic q_t q_mul(input q_t a, input q_t b);
    logic signed [63:0] p;
    p = a * b;
    return q_clamp(p >>> QF);
  endfunction

  // saturating add or subtract
  function automatic q_t q_addsub(input q_t a, input q_t b, input logic sub);
    logic signed [63:0] s;
    if (sub) s = a - b;
    else     s = a + b;
    return q_clamp(s);
  endfunction

  // coefficient table in units of 2^-10, scaled up to Q2.30
  function automatic q_t biq_coef(input int set, input int sec, input int idx);
    int k [NCOEF];
    case (set * NSEC + sec)
      0: k = '{1000, -2000, 1000, -1960,  940};
      1: k = '{1010, -1900, 1010, -1880,  990};
      2: k = '{1015, -1910, 1015, -1890, 1000};
      3: k = '{1020, -1920, 1020, -1900, 1005};
      4: k = '{ 990, -1980,  990, -1940,  920};
      5: k = '{1005, -1820, 1005, -1800,  980};
      6: k = '{1010, -1830, 1010, -1810,  985};
      default: k = '{1012, -1840, 1012, -1820,  990};
    endcase
    return q_t'(k[idx] * 1048576);
  endfunction
endpackage

// File: rtl/biq_arith_pipe.sv
module biq_arith_pipe
  import biq_pkg::*;
#(
  parameter int LAT    = 25,
  parameter bit IS_MUL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic sub,
  input  q_t   a,
  input  q_t   b,
  output logic done,
  output q_t   res,
  output logic pending
);
  q_t          f;
  logic [LAT-1:0] vld;
  q_t          dat [LAT];

  generate
    if (IS_MUL) begin : g_mul
      // sub negates the product
      always_comb f = sub ? q_addsub('0, q_mul(a, b), 1'b1) : q_mul(a, b);
    end else begin : g_add
      always_comb f = q_addsub(a, b, sub);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) vld[0] <= 1'b0;
    else     vld[0] <= go;
    dat[0] <= f;
  end

  generate
    for (genvar i = 1; i < LAT; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) vld[i] <= 1'b0;
        else     vld[i] <= vld[i-1];
        dat[i] <= dat[i-1];
      end
    end
  endgenerate

  assign done    = vld[LAT-1];
  assign res     = dat[LAT-1];
  assign pending = |vld;
endmodule

// File: rtl/biq_state_mem.sv
module biq_state_mem
  import biq_pkg::*;
#(
  parameter int N_SEC = NSEC,
  localparam int SW   = $clog2(N_SEC)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [SW-1:0] sec,
  input  q_t            w_new,
  output q_t            w1,
  output q_t            w2
);
  q_t d1 [N_SEC];
  q_t d2 [N_SEC];

  generate
    for (genvar s = 0; s < N_SEC; s++) begin : g_sec
      always_ff @(posedge clk) begin
        if (rst) begin
          d1[s] <= '0;
          d2[s] <= '0;
        end else if (we && (sec == SW'(s))) begin
          d2[s] <= d1[s];
          d1[s] <= w_new;
        end
      end
    end
  endgenerate

  assign w1 = d1[sec];
  assign w2 = d2[sec];
endmodule

// File: rtl/biq_coef_sel.sv
module biq_coef_sel
  import biq_pkg::*;
#(
  localparam int SEL_W = $clog2(NSETS),
  localparam int SW    = $clog2(NSEC)
) (
  input  logic [SEL_W-1:0] set,
  input  logic [SW-1:0]    sec,
  input  logic [2:0]       idx,
  output q_t               coef
);
  always_comb coef = biq_coef(int'(set), int'(sec), int'(idx));
endmodule

// File: rtl/biq_cascade_engine.sv
module biq_cascade_engine
  import biq_pkg::*;
#(
  parameter int IN_W    = 16,
  parameter int MUL_LAT = 25,
  parameter int ADD_LAT = 25,
  localparam int SEL_W  = $clog2(NSETS),
  localparam int SW     = $clog2(NSEC),
  localparam int SHIFT  = QF - (IN_W - 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  input  logic [SEL_W-1:0] rate_sel,
  output logic             out_valid,
  output logic [QW-1:0]    out_data,
  output logic             busy,
  output logic             overrun
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_UPD} st_e;
  localparam logic [3:0] LAST_STEP = 4'd8;

  st_e              st;
  logic [3:0]       step;
  logic [SW-1:0]    sec;
  logic [SEL_W-1:0] set_q;
  q_t x_r, t_r, w_r, acc_r, m_r;

  // named events
  logic sample_accept, sample_drop, step_is_mul, mul_go, add_go;
  logic mul_done, add_done, mul_pending, add_pending, res_ready, sec_upd;
  q_t   op_a, op_b, coef, w1, w2, mul_res, add_res;
  logic op_sub;
  logic [2:0] cidx;

  assign busy          = (st != S_IDLE);
  assign sample_accept = in_valid && !busy;
  assign sample_drop   = in_valid && busy;
  assign sec_upd       = (st == S_UPD);
  assign res_ready     = mul_done || add_done;

  // step decode: which unit and which coefficient
  always_comb begin
    step_is_mul = 1'b0;
    cidx        = CI_B0;
    case (step)
      4'd0: begin step_is_mul = 1'b1; cidx = CI_A1; end
      4'd2: begin step_is_mul = 1'b1; cidx = CI_A2; end
      4'd4: begin step_is_mul = 1'b1; cidx = CI_B0; end
      4'd5: begin step_is_mul = 1'b1; cidx = CI_B1; end
      4'd7: begin step_is_mul = 1'b1; cidx = CI_B2; end
      default: ;
    endcase
  end

  // operand routing
  always_comb begin
    op_a   = coef;
    op_b   = '0;
    op_sub = 1'b0;
    case (step)
      4'd0, 4'd5: op_b = w1;
      4'd2, 4'd7: op_b = w2;
      4'd4:       op_b = w_r;
      4'd1: begin op_a = x_r; op_b = m_r; op_sub = 1'b1; end
      4'd3: begin op_a = t_r; op_b = m_r; op_sub = 1'b1; end
      default: begin op_a = acc_r; op_b = m_r; end
    endcase
  end

  assign mul_go = (st == S_ISSUE) && step_is_mul;
  assign add_go = (st == S_ISSUE) && !step_is_mul;

  biq_coef_sel u_coef (
    .set(set_q), .sec(sec), .idx(cidx), .coef(coef)
  );

  biq_state_mem #(.N_SEC(NSEC)) u_state (
    .clk(clk), .rst(rst), .we(sec_upd), .sec(sec), .w_new(w_r),
    .w1(w1), .w2(w2)
  );

  biq_arith_pipe #(.LAT(MUL_LAT), .IS_MUL(1'b1)) u_mul (
    .clk(clk), .rst(rst), .go(mul_go), .sub(1'b0), .a(op_a), .b(op_b),
    .done(mul_done), .res(mul_res), .pending(mul_pending)
  );

  biq_arith_pipe #(.LAT(ADD_LAT), .IS_MUL(1'b0)) u_add (
    .clk(clk), .rst(rst), .go(add_go), .sub(op_sub), .a(op_a), .b(op_b),
    .done(add_done), .res(add_res), .pending(add_pending)
  );

  // sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      step      <= '0;
      sec       <= '0;
      set_q     <= '0;
      x_r       <= '0;
      t_r       <= '0;
      w_r       <= '0;
      acc_r     <= '0;
      m_r       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      overrun   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (sample_drop) overrun <= 1'b1;
      case (st)
        S_IDLE: if (sample_accept) begin
          x_r   <= q_t'($signed(in_data)) <<< SHIFT;
          set_q <= rate_sel;
          sec   <= '0;
          step  <= '0;
          st    <= S_ISSUE;
        end
        S_ISSUE: st <= S_WAIT;
        S_WAIT: if (res_ready) begin
          if (mul_done) begin
            if (step == 4'd4) acc_r <= mul_res;
            else              m_r   <= mul_res;
          end else begin
            case (step)
              4'd1:    t_r   <= add_res;
              4'd3:    w_r   <= add_res;
              default: acc_r <= add_res;
            endcase
          end
          if (step == LAST_STEP) st <= S_UPD;
          else begin
            step <= step + 4'd1;
            st   <= S_ISSUE;
          end
        end
        S_UPD: begin
          x_r  <= acc_r;
          step <= '0;
          if (sec == SW'(NSEC - 1)) begin
            out_data  <= acc_r;
            out_valid <= 1'b1;
            st        <= S_IDLE;
          end else begin
            sec <= sec + 1'b1;
            st  <= S_ISSUE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/biq_chain_chk.sv
module biq_chain_chk (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic busy,
  input logic overrun,
  input logic out_valid,
  input logic mul_go,
  input logic add_go,
  input logic mul_pending,
  input logic add_pending
);
  a_r3_one_issue: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mul_go, add_go}));

  a_r4_wait_result: assert property (@(posedge clk) disable iff (rst)
    (mul_go || add_go) |-> !(mul_pending || add_pending));

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  a_r5_out_idle: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !busy);

  a_r9_drop_flags: assert property (@(posedge clk) disable iff (rst)
    (in_valid && busy) |=> overrun);

  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

  a_r10_reset_idle: assert property (@(posedge clk)
    rst |=> (!busy && !out_valid && !overrun));
endmodule

bind biq_cascade_engine biq_chain_chk chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .busy(busy),
  .overrun(overrun), .out_valid(out_valid), .mul_go(mul_go),
  .add_go(add_go), .mul_pending(mul_pending), .add_pending(add_pending)
);

// File: tb/biq_cascade_engine_tb_top.sv
`timescale 1ns/1ps
module biq_cascade_engine_tb_top;
  localparam int IN_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [IN_W-1:0] in_data = '0;
  logic [0:0] rate_sel = '0;
  logic out_valid, busy, overrun;
  logic [31:0] out_data;

  int n_chk = 0;
  int n_bad = 0;
  longint rw1 [4];
  longint rw2 [4];

  always #2.5 clk = ~clk;

  biq_cascade_engine dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .rate_sel(rate_sel), .out_valid(out_valid), .out_data(out_data),
    .busy(busy), .overrun(overrun)
  );

  // ---- independent Q2.30 reference ----
  function automatic longint sat32(input longint v);
    longint hi = 64'sd2147483647;
    longint lo = -64'sd2147483648;
    return (v > hi) ? hi : ((v < lo) ? lo : v);
  endfunction
  function automatic longint rmul(input longint a, input longint b);
    return sat32((a * b) >>> 30);
  endfunction
  function automatic longint cf(input int set, input int sec, input int i);
    return longint'(biq_pkg::biq_coef(set, sec, i));
  endfunction

  function automatic longint ref_step(input longint xin, input int set);
    longint x = xin;
    for (int s = 0; s < 4; s++) begin
      longint t, w, acc;
      t   = sat32(x - rmul(cf(set, s, 3), rw1[s]));
      w   = sat32(t - rmul(cf(set, s, 4), rw2[s]));
      acc = rmul(cf(set, s, 0), w);
      acc = sat32(acc + rmul(cf(set, s, 1), rw1[s]));
      acc = sat32(acc + rmul(cf(set, s, 2), rw2[s]));
      rw2[s] = rw1[s];
      rw1[s] = w;
      x = acc;
    end
    return x;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int s = 0; s < 4; s++) begin rw1[s] = 0; rw2[s] = 0; end
  endtask

  // send one sample, wait for result, compare value and latency
  task automatic send_cmp(input int v, input int set, input string req);
    longint exp, act;
    int cyc = 0;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = IN_W'(v);
    rate_sel = 1'(set);
    @(negedge clk);
    in_valid = 1'b0;
    cyc = 1;
    while (!out_valid && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
    // R1 input scaling: value << 15
    exp = ref_step(longint'(v) <<< 15, set);
    act = longint'($signed(out_data));
    check(act == exp, req, "output sample", act, exp);
    check(cyc >= 900 && cyc <= 1000, "R4/R8", "latency cycles", cyc, 941);
  endtask

  task automatic t_reset_state();
    check(busy == 1'b0, "R10", "busy after reset", busy, 0);
    check(out_valid == 1'b0, "R10", "out_valid after reset", out_valid, 0);
    check(overrun == 1'b0, "R10", "overrun after reset", overrun, 0);
  endtask

  task automatic t_impulse(input int set, input string req);
    do_reset();
    send_cmp(16384, set, req);
    for (int i = 0; i < 5; i++) send_cmp(0, set, req);
  endtask

  task automatic t_step();
    do_reset();
    for (int i = 0; i < 6; i++) send_cmp(8192, 0, "R2/R6 step");
    send_cmp(-32768, 0, "R1 negative full scale");
  endtask

  task automatic t_overrun();
    int stray = 0;
    do_reset();
    send_cmp(12000, 0, "R9 prime");
    @(negedge clk);
    in_valid = 1'b1; in_data = IN_W'(5000); rate_sel = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (20) @(negedge clk);
    // strobe while busy: R9 drop
    in_valid = 1'b1; in_data = IN_W'(30000);
    @(negedge clk);
    in_valid = 1'b0;
    check(overrun == 1'b1, "R9", "overrun after drop", overrun, 1);
    while (!out_valid) @(negedge clk);
    begin
      longint exp = ref_step(longint'(5000) <<< 15, 0);
      check(longint'($signed(out_data)) == exp, "R9", "kept sample",
            longint'($signed(out_data)), exp);
    end
    for (int i = 0; i < 1200; i++) begin
      @(negedge clk);
      if (out_valid) stray++;
    end
    check(stray == 0, "R9", "outputs from dropped sample", stray, 0);
    send_cmp(-7000, 0, "R9 state untouched");
    check(overrun == 1'b1, "R9", "overrun sticky", overrun, 1);
  endtask

  task automatic t_reset_clears();
    send_cmp(20000, 1, "R6 prime");
    do_reset();
    t_reset_state();
    send_cmp(16384, 0, "R10 fresh impulse");
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_impulse(0, "R2/R5 impulse set0");
    t_step();
    t_impulse(1, "R7 impulse set1");
    t_overrun();
    t_reset_clears();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule